// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Sequencer

This block is the controller side of a two-wire bus. It fetches bytes from a serial memory target. One strobe starts a transfer and carries four things: the target's three strap bits, a word address, a byte count and a mode bit. The engine then builds the whole bus sequence without further help. It drives SCL from a programmable divider and pulls SDA low open-drain. It hands each byte it receives to the user on a one-cycle valid pulse. At the end it raises a one-cycle done pulse, with a failure flag and a code for the phase that failed.

The two modes differ in how the transfer opens. In the addressed mode the engine first loads the word address with a device byte marked as a write. It then omits both the data byte and the STOP, so the target never starts an internal write cycle. A repeated START follows at once, then a device byte marked as a read. The current-address mode skips the address load and reads from wherever the target's own pointer stands. In both modes the engine acknowledges every received byte except the final one. It leaves the final one unacknowledged on its ninth clock and then closes with a STOP.

Top module: `twr_rd_seq`

## Requirements
- R1: After reset and after every finished transfer, busy is low and both scl_pull and sda_pull are low, so both lines are released high.
- R2: Every device byte is sent MSB first with bit pattern 1,0,1,0, then cmd_strap[2:0] (bit 2 first), then the direction bit: 0 when the word address follows, 1 when data is read.
- R3: With cmd_mode=0 the bus order is START, device byte (write), cmd_word, repeated START, device byte (read), data bytes, STOP. No data byte and no STOP is sent between cmd_word and the repeated START.
- R4: With cmd_mode=1 the bus order is START, device byte (read), data bytes, STOP, with no word address phase.
- R5: A transfer delivers exactly cmd_len bytes on rd_valid/rd_byte, in bus order, with cmd_len=0 treated as 1. For every byte except the last, the engine pulls SDA low on the ninth clock.
- R6: On the ninth clock of the last byte SDA is left released (NACK). A STOP follows, and then done pulses for one cycle with fail low.
- R7: If a byte the engine sends is not acknowledged (SDA high at the ninth clock), no further byte is sent. The engine issues a STOP and pulses done with fail=1. fail_phase is 0 for the write device byte, 1 for the word address and 2 for the read device byte. No data is delivered. fail and fail_phase hold until the next accepted command.
- R8: While busy, every SCL low and every SCL high interval lasts exactly DIV clocks. The engine changes SDA only while SCL is low, except for its own START and STOP edges.
- R9: cmd_valid is ignored while busy, and the running transfer proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_mode | input | 1 | 0 = addressed read, 1 = current-address read |
| cmd_strap | input | 3 | Target strap bits placed in the device byte |
| cmd_word | input | 8 | Word address for addressed mode |
| cmd_len | input | LENW | Number of bytes to read (0 means 1) |
| busy | output | 1 | Transfer in progress |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved level of the SDA line |
| rd_valid | output | 1 | One-cycle pulse: rd_byte holds a received byte |
| rd_byte | output | 8 | Received data byte |
| done | output | 1 | One-cycle pulse when the closing STOP completes |
| fail | output | 1 | Last transfer ended on a missing acknowledge |
| fail_phase | output | 2 | Phase that was not acknowledged |

## Verification
Most internal faults reach the wire well before any data does. A wrong phase or state shows up as a missing or extra START or STOP, or a wrong byte, in the bus event log that the target model records. An off-by-one in the bit counter moves every later bit, so the device byte already fails the comparison and the corrupted byte lands in the log. A byte-count or ACK/NACK fault shows up on the ninth clock of the affected byte and in the number of valid pulses before done. A divider fault changes the length of the first SCL low interval after a command is accepted, within the first DIV+1 clocks.

// File: rtl/twr_rd_seq.sv
module twr_rd_seq #(
  parameter int DIV  = 4,
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_mode,
  input  logic [2:0]      cmd_strap,
  input  logic [7:0]      cmd_word,
  input  logic [LENW-1:0] cmd_len,
  output logic            busy,
  output logic            scl_pull,
  output logic            sda_pull,
  input  logic            sda_in,
  output logic            rd_valid,
  output logic [7:0]      rd_byte,
  output logic            done,
  output logic            fail,
  output logic [1:0]      fail_phase
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] HALF_END = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_MID = CW'(DIV / 2);

  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_START = 2'd1;
  localparam logic [1:0] ST_BITS  = 2'd2;
  localparam logic [1:0] ST_STOP  = 2'd3;

  localparam logic [1:0] PH_DEVW = 2'd0;
  localparam logic [1:0] PH_WORD = 2'd1;
  localparam logic [1:0] PH_DEVR = 2'd2;
  localparam logic [1:0] PH_DATA = 2'd3;

  logic [1:0]      st, ph;
  logic [CW-1:0]   cnt;
  logic            half;
  logic [3:0]      bitn;
  logic [7:0]      tx, rx, word;
  logic [LENW-1:0] left;
  logic [2:0]      strap;
  logic            sda_low, ack_bad;
  logic            at_mid, at_end, slot_end, talk, in_ack, last_byte;

  assign busy      = st != ST_IDLE;
  assign scl_pull  = busy && !half;
  assign sda_pull  = sda_low;
  assign at_mid    = cnt == HALF_MID;
  assign at_end    = cnt == HALF_END;
  assign slot_end  = half && at_end;
  assign talk      = ph != PH_DATA;
  assign in_ack    = bitn == 4'd8;
  assign last_byte = left == LENW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= PH_DEVW;
      cnt        <= '0;
      half       <= 1'b0;
      bitn       <= 4'd0;
      tx         <= 8'd0;
      rx         <= 8'd0;
      word       <= 8'd0;
      left       <= '0;
      strap      <= 3'd0;
      sda_low    <= 1'b0;
      ack_bad    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_byte    <= 8'd0;
      done       <= 1'b0;
      fail       <= 1'b0;
      fail_phase <= 2'd0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == ST_IDLE) begin
        cnt     <= '0;
        half    <= 1'b0;
        sda_low <= 1'b0;
        if (cmd_valid) begin
          st         <= ST_START;
          ph         <= cmd_mode ? PH_DEVR : PH_DEVW;
          strap      <= cmd_strap;
          word       <= cmd_word;
          left       <= (cmd_len == '0) ? LENW'(1) : cmd_len;
          ack_bad    <= 1'b0;
          fail       <= 1'b0;
          fail_phase <= 2'd0;
        end
      end else begin
        if (at_end) begin
          cnt  <= '0;
          half <= ~half;
        end else begin
          cnt <= cnt + 1'b1;
        end
        case (st)
          ST_START: begin
            if (at_mid) sda_low <= half;
            if (slot_end) begin
              st   <= ST_BITS;
              bitn <= 4'd0;
              tx   <= {4'b1010, strap, ph == PH_DEVR};
            end
          end
          ST_BITS: begin
            if (at_mid && !half) begin
              if (!in_ack) sda_low <= talk && !tx[7];
              else         sda_low <= !talk && !last_byte;
            end
            if (at_mid && half) begin
              if (!in_ack) rx <= {rx[6:0], sda_in};
              else if (talk) ack_bad <= sda_in;
              else begin
                rd_valid <= 1'b1;
                rd_byte  <= rx;
              end
            end
            if (slot_end) begin
              if (!in_ack) begin
                bitn <= bitn + 4'd1;
                tx   <= {tx[6:0], 1'b0};
              end else begin
                bitn <= 4'd0;
                if (talk && ack_bad) begin
                  st <= ST_STOP;
                end else begin
                  case (ph)
                    PH_DEVW: begin
                      ph <= PH_WORD;
                      tx <= word;
                    end
                    PH_WORD: begin
                      ph <= PH_DEVR;
                      st <= ST_START;
                    end
                    PH_DEVR: ph <= PH_DATA;
                    default: begin
                      if (last_byte) st <= ST_STOP;
                      else left <= left - 1'b1;
                    end
                  endcase
                end
              end
            end
          end
          default: begin
            if (at_mid) sda_low <= !half;
            if (slot_end) begin
              st         <= ST_IDLE;
              done       <= 1'b1;
              fail       <= ack_bad;
              fail_phase <= ack_bad ? ph : 2'd0;
            end
          end
        endcase
      end
    end
  end

  // R1
  idle_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_pull);

  // R8
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS && half && cnt != '0) |-> $stable(sda_pull));

  // R5
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> left != '0);

  // R5
  data_in_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (st == ST_BITS && ph == PH_DATA));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  fail_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done && fail_phase != PH_DATA);

  // R9
  start_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
endmodule

// File: tb/twr_rd_seq_test.sv
`timescale 1ns/1ps
module twr_rd_seq_test;
  localparam int DIV = 4;
  localparam logic [2:0] TSTRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_mode = 1'b0;
  logic [2:0] cmd_strap = 3'd0;
  logic [7:0] cmd_word = 8'd0, cmd_len = 8'd0;
  logic busy, scl_pull, sda_pull, rd_valid, done, fail;
  logic [7:0] rd_byte;
  logic [1:0] fail_phase;
  logic tgt_pull = 1'b0;
  logic scl_w, sda_w;

  always #2 clk = ~clk;

  assign scl_w = ~scl_pull;
  assign sda_w = ~(sda_pull | tgt_pull);

  twr_rd_seq #(.DIV(DIV), .LENW(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_strap(cmd_strap), .cmd_word(cmd_word), .cmd_len(cmd_len),
    .busy(busy), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_w),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .done(done), .fail(fail),
    .fail_phase(fail_phase)
  );

  int checks = 0, fails = 0, wd = 0;

  function automatic logic [7:0] memv(input logic [7:0] a);
    return (a * 8'd29 + 8'h5b) ^ {a[3:0], a[7:4]};
  endfunction

  function automatic logic [9:0] ev(input logic [1:0] t, input logic [7:0] v);
    return {t, v};
  endfunction

  // bus log event types: 0 controller ack bit (value = SDA), 1 START, 2 STOP, 3 byte sent by controller
  logic [9:0] tlog [0:2047];
  int tlen = 0;
  bit knob_nack_word = 0, knob_nack_rd = 0;
  bit pscl, psda, acking, ackd, is_dev;
  int tst, bitc, rbit;
  logic [7:0] sh, outb, ptr;

  task automatic tpush(input logic [1:0] t, input logic [7:0] v);
    if (tlen < 2048) tlog[tlen] = ev(t, v);
    tlen++;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      pscl = 1; psda = 1; tst = 0; tgt_pull = 0; ptr = 8'd0;
      acking = 0; ackd = 0; is_dev = 0; bitc = 0; rbit = 0; sh = 0; outb = 0;
    end else begin
      if (pscl && scl_w && psda && !sda_w) begin
        tpush(2'd1, 8'd0); tst = 1; bitc = 0; is_dev = 1; acking = 0; tgt_pull = 0;
      end else if (pscl && scl_w && !psda && sda_w) begin
        tpush(2'd2, 8'd0); tst = 0; tgt_pull = 0;
      end else if (tst == 1) begin
        if (!pscl && scl_w && bitc < 8) begin
          sh = {sh[6:0], sda_w}; bitc++;
        end else if (pscl && !scl_w && bitc == 8 && !acking) begin
          tpush(2'd3, sh);
          acking = 1;
          if (is_dev) ackd = (sh[7:1] == {4'b1010, TSTRAP}) && !(sh[0] && knob_nack_rd);
          else begin
            ackd = !knob_nack_word;
            if (ackd) ptr = sh;
          end
          tgt_pull = ackd;
        end else if (pscl && !scl_w && acking) begin
          acking = 0; tgt_pull = 0; bitc = 0;
          if (!ackd) tst = 0;
          else if (is_dev && sh[0]) begin
            tst = 2; rbit = 0; outb = memv(ptr); tgt_pull = ~outb[7];
          end else is_dev = 0;
        end
      end else if (tst == 2) begin
        if (!pscl && scl_w && rbit == 8) begin
          tpush(2'd0, {7'd0, sda_w});
          ptr = ptr + 8'd1; outb = memv(ptr);
          if (sda_w) tst = 3;
        end else if (pscl && !scl_w) begin
          if (rbit < 7) begin rbit++; tgt_pull = ~outb[7-rbit]; end
          else if (rbit == 7) begin rbit = 8; tgt_pull = 0; end
          else begin rbit = 0; tgt_pull = ~outb[7]; end
        end
      end
      pscl = scl_w; psda = sda_w;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic [9:0] exl [0:31];
  int exn;
  logic [7:0] ref_ptr = 8'd0;

  task automatic xpush(input logic [1:0] t, input logic [7:0] v);
    exl[exn] = ev(t, v); exn++;
  endtask

  task automatic run_op(input bit md, input logic [2:0] sp, input logic [7:0] wa, input logic [7:0] ln,
                        input bit nw, input bit nr, input bit poke);
    logic [7:0] dev, start;
    bit xf, prev, clean, tbad, ok;
    int xph, nexp, base, got, cyc, run;
    knob_nack_word = nw; knob_nack_rd = nr;
    dev = {4'b1010, sp, 1'b0};
    xf = 0; xph = 0; nexp = 0; exn = 0; start = 8'd0;
    xpush(2'd1, 8'd0);
    if (!md) begin
      xpush(2'd3, dev);
      if (sp != TSTRAP) begin xf = 1; xph = 0; end
      else begin
        xpush(2'd3, wa);
        if (nw) begin xf = 1; xph = 1; end
        else begin
          ref_ptr = wa;
          xpush(2'd1, 8'd0); xpush(2'd3, dev | 8'h01);
          if (nr) begin xf = 1; xph = 2; end
        end
      end
    end else begin
      xpush(2'd3, dev | 8'h01);
      if (sp != TSTRAP || nr) begin xf = 1; xph = 2; end
    end
    if (!xf) begin
      nexp = (ln == 8'd0) ? 1 : int'(ln);
      start = ref_ptr;
      for (int k = 0; k < nexp; k++) xpush(2'd0, {7'd0, k == nexp - 1});
      ref_ptr = ref_ptr + 8'(nexp);
    end
    xpush(2'd2, 8'd0);

    base = tlen;
    cmd_mode = md; cmd_strap = sp; cmd_word = wa; cmd_len = ln; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check(busy, "R9", "busy after accept", busy, 1);
    got = 0; cyc = 0; prev = 1; clean = 0; run = 0; tbad = 0;
    while (cyc < 6000) begin
      if (rd_valid) begin
        if (got < nexp)
          check(rd_byte == memv(start + 8'(got)), "R5", "data byte", rd_byte, memv(start + 8'(got)));
        got++;
      end
      if (scl_w != prev) begin
        if (clean && run != DIV) tbad = 1;
        run = 1; clean = busy;
      end else begin
        run++;
      end
      if (!busy) clean = 0;
      prev = scl_w;
      if (done) break;
      if (poke && cyc == 40) begin
        cmd_valid = 1; cmd_mode = ~md; cmd_strap = ~sp; cmd_word = ~wa; cmd_len = 8'd3;
      end
      if (poke && cyc == 41) cmd_valid = 0;
      @(negedge clk);
      cyc++;
    end
    check(cyc < 6000, xf ? "R7" : "R6", "done seen", cyc, 0);
    check(got == nexp, "R5", "byte count", got, nexp);
    check(fail == xf, "R7", "fail flag", fail, xf);
    if (xf) check(fail_phase == 2'(xph), "R7", "fail phase", fail_phase, xph);
    ok = (tlen - base == exn);
    for (int k = 0; k < exn; k++) if (ok && tlog[base + k] != exl[k]) ok = 0;
    check(ok, xf ? "R7" : (md ? "R4" : "R3"), "bus sequence", tlen - base, exn);
    if (poke) check(ok, "R9", "sequence with strobe while busy", tlen - base, exn);
    if (tlen > base + 1)
      check(tlog[base + 1] == ev(2'd3, dev | {7'd0, md}), "R2", "device byte", tlog[base + 1], ev(2'd3, dev | {7'd0, md}));
    if (!xf && tlen >= base + 2)
      check(tlog[tlen - 2] == ev(2'd0, 8'd1), "R6", "final nack", tlog[tlen - 2], ev(2'd0, 8'd1));
    check(!tbad, "R8", "scl half length", tbad, 0);
    check(!busy && scl_w && sda_w, "R1", "lines released at done", {busy, scl_w, sda_w}, 3'b011);
    repeat (5) @(negedge clk);
    check(!busy && !scl_pull && !sda_pull, "R1", "idle after op", {busy, scl_pull, sda_pull}, 0);
  endtask

  initial begin
    logic [31:0] sd;
    sd = $urandom(32'h1D2C3B4A);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !scl_pull && !sda_pull && !done && !rd_valid, "R1", "reset state",
          {busy, scl_pull, sda_pull, done, rd_valid}, 0);
    run_op(0, TSTRAP, 8'h10, 8'd1, 0, 0, 0);
    run_op(0, TSTRAP, 8'hFE, 8'd3, 0, 0, 0);
    run_op(1, TSTRAP, 8'h00, 8'd2, 0, 0, 0);
    run_op(1, TSTRAP, 8'h00, 8'd0, 0, 0, 0);
    run_op(0, 3'b011, 8'h44, 8'd2, 0, 0, 0);
    run_op(1, 3'b000, 8'h44, 8'd2, 0, 0, 0);
    run_op(0, TSTRAP, 8'h55, 8'd2, 1, 0, 0);
    run_op(0, TSTRAP, 8'h66, 8'd2, 0, 1, 0);
    run_op(1, TSTRAP, 8'h00, 8'd1, 0, 0, 0);
    run_op(0, TSTRAP, 8'h80, 8'd8, 0, 0, 1);
    for (int i = 0; i < 20; i++) begin
      logic [2:0] sp;
      sp = ($urandom % 5 == 0) ? 3'($urandom) : TSTRAP;
      run_op(1'($urandom), sp, 8'($urandom), 8'($urandom % 7),
             ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule